// File: doc/BRIEF.md
# Multi-Channel Match-Based PWM Timer

A 32-bit timer whose count advances once per prescaler period, compared every count against seven match values. Match value 0 fixes the cycle length that all outputs share. The other six values place the edges of six PWM outputs. Each output is either single-edge, set at the start of every cycle and cleared at its own match, or double-edge, set by one match and cleared by the next. In double-edge mode the order of the two values decides whether the pulse is positive-going or negative-going.

Software programs the block through one write port. While PWM mode is on, new match values land in shadow registers. A shadow value moves into the compare logic only at a cycle boundary, and only after software has armed it. This keeps a half-updated pair of edges from ever reaching a pin. Each match can raise a sticky interrupt flag, restart the count or stop the timer. With PWM mode off the block is a plain timer: the outputs stay low and match writes take effect at once.

Top module: `pwm_match_timer`

## Requirements
- R1: An internal prescale count runs from 0 up to the limit at address 7. A limit L therefore advances `count_o` by one every L+1 clocks. Counting needs control bit 0 (run) set and control bit 1 (hold) clear. While hold is set, the count is forced to 0. The control register is at address 12.
- R2: A match on value k happens on the clock where the prescaler completes while `count_o` equals value k. If action bit 3k+1 (address 8) is set, the count goes to 0 instead of incrementing. With this action on match 0, a cycle lasts value0+1 counts.
- R3: If action bit 3k+2 is set, a match on value k clears the run bit, and `count_o` keeps the matched value.
- R4: If action bit 3k is set, a match on value k sets `irq_flags_o[k]`. The flag stays set until a 1 is written to bit k at address 11; writing 0 leaves it unchanged. A new match wins over a clear in the same cycle. `irq_o` is the OR of all flags.
- R5: With bit j clear at address 9, `pwm_o[j]` is single-edge. It is set on a match 0 and cleared on a match j+1. For a cycle value P and a clear value W, it is high W+1 clocks per cycle when W<P, stays constantly low when W equals P, and stays constantly high when W>P.
- R6: With bit j set at address 9, `pwm_o[j]` is double-edge. It is set on a match j and cleared on a match j+1. A set value S and a clear value C give C−S high clocks per cycle when S<C (a positive pulse), and P+1−(S−C) when C<S (a negative pulse).
- R7: When a set event and a clear event for one output happen in the same cycle, the clear wins. Equal double-edge values therefore hold the output low.
- R8: In PWM mode, a write to address k (0–6) changes only shadow value k. Writing 1 to bit k at address 10 arms it. At the next match 0 an armed shadow value is copied into the compare logic and its arm bit clears by itself. A later shadow write then stays unused until it is armed again.
- R9: With control bit 2 (PWM mode) clear, `pwm_o` is held at 0 and a write to address k sets match value k immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| pwm_o | output | 6 | PWM outputs |
| irq_o | output | 1 | Interrupt request, OR of flags |
| irq_flags_o | output | 7 | Sticky per-match interrupt flags |
| count_o | output | 32 | Current timer count |

## Verification
A write lands on the rising edge after it is presented, so its effect is sampled no earlier than the falling edge that follows. Count steps, flags and output edges all register on the edge where a match completes, and the bench samples them on falling edges. Duty is measured by counting the high samples over one full cycle of value0+1 clocks, after two cycles of settling, so the phase at which measurement starts does not matter. Values that should not change, such as a held count, an unarmed shadow write or a write of 0 to the flags, are checked several cycles later through `count_o`, `pwm_o` and `irq_flags_o`.

// File: rtl/pwm_match_timer.sv
module pwm_match_timer #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 32,
  parameter int NOUT = 6,
  localparam int NM = NOUT + 1,
  localparam int AW = $clog2(NM + 6)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [NOUT-1:0]  pwm_o,
  output logic             irq_o,
  output logic [NM-1:0]    irq_flags_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int A_PRE = NM;
  localparam int A_ACT = NM + 1;
  localparam int A_DBL = NM + 2;
  localparam int A_LAT = NM + 3;
  localparam int A_FLG = NM + 4;
  localparam int A_CTL = NM + 5;

  logic [CNT_W-1:0] shadow [NM];
  logic [CNT_W-1:0] active [NM];
  logic [PRE_W-1:0] pre_lim, pre_cnt;
  logic [3*NM-1:0]  act;
  logic [NOUT-1:0]  dbl, pwm_q, set_e, clr_e;
  logic [NM-1:0]    latch, flags, hit, on_irq, on_rst, on_stop, wr_mr, xfer;
  logic             run, hold, pwm_en, tick;
  logic [CNT_W-1:0] cnt;

  wire wr_pre = wr_en && (wr_addr == AW'(A_PRE));
  wire wr_act = wr_en && (wr_addr == AW'(A_ACT));
  wire wr_dbl = wr_en && (wr_addr == AW'(A_DBL));
  wire wr_lat = wr_en && (wr_addr == AW'(A_LAT));
  wire wr_flg = wr_en && (wr_addr == AW'(A_FLG));
  wire wr_ctl = wr_en && (wr_addr == AW'(A_CTL));

  assign tick = run && !hold && (pre_cnt >= pre_lim);
  assign xfer = latch & {NM{pwm_en && hit[0]}};

  always_comb begin
    for (int k = 0; k < NM; k++) begin
      on_irq[k]  = act[3*k];
      on_rst[k]  = act[3*k+1];
      on_stop[k] = act[3*k+2];
      hit[k]     = tick && (cnt == active[k]);
      wr_mr[k]   = wr_en && (wr_addr == AW'(k));
    end
    for (int j = 0; j < NOUT; j++) begin
      set_e[j] = dbl[j] ? hit[j] : hit[0];
      clr_e[j] = hit[j+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NM; k++) begin
        shadow[k] <= '0;
        active[k] <= '0;
      end
      latch <= '0;
    end else begin
      for (int k = 0; k < NM; k++) begin
        if (wr_mr[k]) shadow[k] <= wr_data;
        if (wr_mr[k] && !pwm_en) active[k] <= wr_data;
        else if (xfer[k]) active[k] <= shadow[k];
      end
      latch <= (latch & ~xfer) | (wr_lat ? wr_data[NM-1:0] : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_lim <= '0;
      act     <= '0;
      dbl     <= '0;
      flags   <= '0;
    end else begin
      if (wr_pre) pre_lim <= wr_data[PRE_W-1:0];
      if (wr_act) act <= wr_data[3*NM-1:0];
      if (wr_dbl) dbl <= wr_data[NOUT-1:0];
      flags <= (flags & ~(wr_flg ? wr_data[NM-1:0] : '0)) | (hit & on_irq);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      hold   <= 1'b0;
      pwm_en <= 1'b0;
    end else if (wr_ctl) begin
      {pwm_en, hold, run} <= wr_data[2:0];
    end else if (|(hit & on_stop)) begin
      run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      cnt     <= '0;
    end else if (hold) begin
      pre_cnt <= '0;
      cnt     <= '0;
    end else if (run) begin
      pre_cnt <= tick ? '0 : pre_cnt + PRE_W'(1);
      if (tick) begin
        if (|(hit & on_rst)) cnt <= '0;
        else if (!(|(hit & on_stop))) cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= '0;
    else pwm_q <= pwm_en ? ((pwm_q | set_e) & ~clr_e) : '0;
  end

  assign pwm_o       = pwm_q & {NOUT{pwm_en}};
  assign irq_o       = |flags;
  assign irq_flags_o = flags;
  assign count_o     = cnt;
endmodule

// File: rtl/pwm_match_timer_chk.sv
module pwm_match_timer_chk #(
  parameter int CNT_W = 32,
  parameter int NOUT = 6,
  localparam int NM = NOUT + 1,
  localparam int AW = $clog2(NM + 6)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [NOUT-1:0]  pwm_o,
  input logic [NM-1:0]    irq_flags_o,
  input logic [CNT_W-1:0] count_o,
  input logic [NM-1:0]    hit,
  input logic [NM-1:0]    on_stop,
  input logic             tick,
  input logic             hold,
  input logic             run,
  input logic             pwm_en,
  input logic [CNT_W-1:0] active [NM]
);
  logic [NM-1:0] clr_mask;
  logic          ctl_wr;
  assign clr_mask = (wr_en && wr_addr == AW'(NM + 4)) ? wr_data[NM-1:0] : '0;
  assign ctl_wr   = wr_en && (wr_addr == AW'(NM + 5));

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_o == $past(count_o) + CNT_W'(1)) || (count_o == $past(count_o)) || (count_o == '0)); // R1

  AST_COUNT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hold) |=> $stable(count_o)); // R1

  AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(hit & on_stop)) && !ctl_wr) |=> !run); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq_flags_o) & ~$past(clr_mask) & ~irq_flags_o) == '0)); // R4

  for (genvar j = 0; j < NOUT; j++) begin : g_out
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en && hit[j+1]) |=> !pwm_o[j]); // R7
  end

  for (genvar k = 0; k < NM; k++) begin : g_mr
    AST_ACTIVE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en && !hit[0]) |=> $stable(active[k])); // R8
  end
endmodule

bind pwm_match_timer pwm_match_timer_chk #(.CNT_W(CNT_W), .NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pwm_o(pwm_o), .irq_flags_o(irq_flags_o), .count_o(count_o),
  .hit(hit), .on_stop(on_stop), .tick(tick), .hold(hold), .run(run),
  .pwm_en(pwm_en), .active(active)
);

// File: tb/pwm_match_timer_test.sv
`timescale 1ns/1ps
module pwm_match_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  pwm_o;
  logic        irq_o;
  logic [6:0]  irq_flags_o;
  logic [31:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_match_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_o(pwm_o), .irq_o(irq_o), .irq_flags_o(irq_flags_o), .count_o(count_o)
  );

  // columns: double-edge, cycle value P, set value (match 1), clear value (match 2), expected high clocks
  localparam int VEC [8][5] = '{
    '{0, 9, 0, 3, 4},
    '{0, 9, 0, 0, 1},
    '{0, 9, 0, 9, 0},
    '{0, 9, 0, 12, 10},
    '{1, 9, 2, 6, 4},
    '{1, 9, 6, 2, 6},
    '{1, 9, 4, 4, 0},
    '{0, 4, 0, 1, 2}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int p, output int h);
    repeat (2 * (p + 1) + 2) @(negedge clk);
    h = 0;
    repeat (p + 1) begin
      @(negedge clk);
      h += int'(pwm_o[1]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL all watchdog: actual expired expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int h;
    int prev;
    repeat (3) @(negedge clk);
    chk("R1", "reset count", count_o, 0);
    chk("R9", "reset pwm", 32'(pwm_o), 0);
    chk("R4", "reset flags", 32'(irq_flags_o), 0);
    rst_n = 1'b1;

    // duty table: R5 single-edge, R6 double-edge, R7 equal values
    wr(8, 32'h2);
    for (int i = 0; i < 8; i++) begin
      string tag;
      tag = (VEC[i][0] == 0) ? "R5" : (VEC[i][2] == VEC[i][3]) ? "R7" : "R6";
      wr(12, 32'h2);
      wr(0, VEC[i][1]);
      wr(1, VEC[i][2]);
      wr(2, VEC[i][3]);
      wr(9, VEC[i][0] != 0 ? 32'h2 : 32'h0);
      wr(12, 32'h5);
      measure(VEC[i][1], h);
      chk(tag, $sformatf("vector %0d high clocks", i), h, VEC[i][4]);
    end

    // R8 shadow and arming
    wr(12, 32'h2);
    wr(0, 9); wr(2, 3); wr(9, 0);
    wr(12, 32'h5);
    measure(9, h);
    chk("R8", "baseline high", h, 4);
    wr(2, 7);
    measure(9, h);
    chk("R8", "unarmed shadow ignored", h, 4);
    wr(10, 32'h4);
    measure(9, h);
    chk("R8", "armed shadow applied", h, 8);
    wr(2, 1);
    measure(9, h);
    chk("R8", "arm bit self-cleared", h, 8);

    // R4 flags
    chk("R4", "no irq action no flag", 32'(irq_flags_o), 0);
    wr(8, 32'h3);
    repeat (12) @(negedge clk);
    chk("R4", "match0 flag", 32'(irq_flags_o), 1);
    chk("R4", "irq line", 32'(irq_o), 1);
    wr(8, 32'h2);
    wr(11, 32'h0);
    repeat (3) @(negedge clk);
    chk("R4", "zero write keeps flag", 32'(irq_flags_o), 1);
    wr(11, 32'h1);
    chk("R4", "one write clears flag", 32'(irq_flags_o), 0);
    chk("R4", "irq line low", 32'(irq_o), 0);

    // R3 stop, R9 timer mode
    wr(12, 32'h2);
    wr(8, 32'hA00);
    wr(3, 5);
    wr(12, 32'h1);
    repeat (20) @(negedge clk);
    chk("R3", "stopped count", count_o, 5);
    chk("R4", "stop match flag", 32'(irq_flags_o), 32'h8);
    chk("R9", "timer mode pwm low", 32'(pwm_o), 0);
    wr(11, 32'h8);

    // R2 restart in timer mode with immediate match write (R9)
    wr(12, 32'h2);
    wr(0, 4);
    wr(8, 32'h2);
    wr(12, 32'h1);
    @(negedge clk);
    prev = int'(count_o);
    for (int i = 0; i < 10; i++) begin
      int exp_c;
      @(negedge clk);
      exp_c = (prev == 4) ? 0 : prev + 1;
      chk("R2", $sformatf("wrap step %0d", i), count_o, exp_c);
      prev = exp_c;
    end

    // R1 prescaler, run gate, hold
    wr(12, 32'h2);
    wr(8, 32'h0);
    wr(7, 3);
    wr(12, 32'h1);
    repeat (8) @(negedge clk);
    chk("R1", "prescaled count", count_o, 2);
    repeat (4) @(negedge clk);
    chk("R1", "prescaled count later", count_o, 3);
    wr(12, 32'h0);
    prev = int'(count_o);
    repeat (10) @(negedge clk);
    chk("R1", "run clear freezes", count_o, prev);
    wr(12, 32'h3);
    @(negedge clk);
    chk("R1", "hold zeroes", count_o, 0);
    repeat (8) @(negedge clk);
    chk("R1", "hold keeps zero", count_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule